// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is the slave side of a three-wire host link: a chip-enable, a serial clock and one data line. The data line is split at the block edge into an input (`sdi`), an output (`sdo`) and an output enable (`sdo_oe`). Through this link a host reaches a small register space. That space holds seven timekeeping registers, a control register and a bank of general-purpose RAM bytes. Every transaction opens with a command byte. The command byte asks for one register, or for a burst that walks the whole clock block or the whole RAM in order.

The timekeeping counters sit outside the block. Their current values arrive on a parallel bus (`tm_in`). A host write to one of them leaves the block as a one-cycle strobe with the written byte. The block holds only the control register and the RAM. The control register carries a write-protect flag.

A burst read of the clock block serves data from a copy of the time taken when the command is accepted. The host therefore gets a coherent set of values while the live counters keep moving. The serial lines are sampled with the system clock `clk`. They must already be synchronous to it, and each serial clock level must last at least two `clk` cycles.

Top module: `tw_reg_slave`

## Requirements
- R1: After reset, `sdo_oe` is low, `tm_wr_en` is all zero and the control register (clock address 7) reads 0x00.
- R2: The command byte and every data byte move least-significant bit first, each bit taken on a rising serial clock edge while `ce` is high. Command bit 0 is the direction (1 = read, 0 = write). Bits 5:1 are the address. Bit 6 selects RAM (1) or the clock block (0). Bit 7 must be 1.
- R3: The RAM holds 31 bytes at RAM addresses 0 to 30. Each byte keeps its value independently of the others and of the clock block.
- R4: A single-byte write to clock address k (0 to 6) gives exactly one pulse on `tm_wr_en[k]`, one `clk` cycle wide, with the byte on `tm_wr_data`. A single-byte read of address k returns the live `tm_in[8k+7:8k]`.
- R5: Address 31 selects burst mode. A clock burst moves addresses 0 to 7 in order: seven time strobes followed by the control register. A RAM burst moves addresses 0 to 30 in order. The transfer steps to the next address after every 8 data bits.
- R6: A clock burst read returns `tm_in` as it stood when the command byte completed, even if `tm_in` changes during the burst.
- R7: While control bit 7 (write protect) is set at command completion, no write takes effect. This covers the whole of a clock burst write (the control register included), RAM writes and time strobes.
- R8: A single-byte write to the control register always takes effect, even while write protect is set, so that protection can be lifted.
- R9: Taking `ce` low ends the transaction at once. A data byte with fewer than 8 bits received is discarded.
- R10: A command byte whose bit 7 is 0 is ignored. It causes no write and never drives the data line.
- R11: For a read, `sdo_oe` rises on the falling serial clock edge that follows the last command bit, and D0 appears on `sdo` at that edge. It stays high until `ce` goes low. During a write, `sdo_oe` stays low.
- R12: Clock addresses 8 to 30 (the charger setting among them) read as 0x00 and ignore writes. Bytes past the end of a burst, and extra bytes after a single-byte transfer, read as 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce | input | 1 | Transaction enable from the host |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Data line as seen by the slave |
| sdo | output | 1 | Data line value driven by the slave |
| sdo_oe | output | 1 | Slave drives the data line when high |
| tm_in | input | TIME_REGS*DATA_W | Live timekeeping registers, address k at bits 8k+7:8k |
| tm_wr_en | output | TIME_REGS | One-hot write strobe per timekeeping register |
| tm_wr_data | output | DATA_W | Byte written with the strobe |

## Verification
The bench builds the block with its defaults: seven time registers, a 31-byte RAM and the snapshot variant. With these values both burst lengths (8 and 31 bytes) and the first byte past each burst's end can be reached. The bench changes `tm_in` in the middle of a clock burst read, so a design that reads live values instead of the copy returns wrong bytes. It also sets the protect flag and then tries every write path: single, clock burst and RAM. It cuts a byte short with `ce`, and it sends a command with a bad top bit.

// File: rtl/tw_pkg.sv
package tw_pkg;

   // Command byte, bit 0 first on the wire.
   typedef struct packed {
      logic       valid;   // bit 7, must be 1
      logic       ram;     // bit 6, 1 selects RAM
      logic [4:0] addr;    // bits 5:1
      logic       rd;      // bit 0, 1 means read
   } tw_cmd_t;

   typedef enum logic [1:0] {
      PH_CMD  = 2'd0,
      PH_DATA = 2'd1,
      PH_HALT = 2'd2
   } tw_phase_e;

   localparam logic [4:0] TW_BURST_ADDR = 5'h1F;

endpackage

// File: rtl/tw_ram.sv
module tw_ram #(
   parameter int DEPTH  = 31,
   parameter int DATA_W = 8,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (we) begin
         mem_q[waddr] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < DEPTH; i++)
         if (raddr == ADDR_W'(i)) rdata = mem_q[i];
   end

   // R3: writes only land inside the array
   a_r3_ram_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (int'(waddr) < DEPTH));

endmodule

// File: rtl/tw_bitlink.sv
module tw_bitlink
   import tw_pkg::*;
#(
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce,
   input  logic             sclk,
   input  logic             sdi,
   input  logic [7:0]       rd_byte,
   output logic             sdo,
   output logic             sdo_oe,
   output tw_cmd_t          cmd_q,
   output tw_cmd_t          cmd_nxt,
   output logic             cmd_stb,
   output logic             wr_stb,
   output logic [7:0]       wr_byte,
   output logic [IDX_W-1:0] idx
);
   localparam logic [IDX_W-1:0] IDX_TOP = '1;

   logic       sclk_q;
   logic [2:0] bit_q, rbit_q;
   logic [7:0] sh_q, osh_q;
   tw_phase_e  ph_q;
   logic       rise, fall, last_bit;

   assign rise     = ce & sclk & ~sclk_q;
   assign fall     = ce & ~sclk & sclk_q;
   assign last_bit = rise && (bit_q == 3'd7);
   assign wr_byte  = {sdi, sh_q[7:1]};
   assign cmd_nxt  = tw_cmd_t'(wr_byte);
   assign cmd_stb  = last_bit && (ph_q == PH_CMD) && cmd_nxt.valid;
   assign wr_stb   = last_bit && (ph_q == PH_DATA) && !cmd_q.rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         bit_q  <= '0;
         rbit_q <= '0;
         sh_q   <= '0;
         osh_q  <= '0;
         ph_q   <= PH_CMD;
         cmd_q  <= '0;
         idx    <= '0;
         sdo    <= 1'b0;
         sdo_oe <= 1'b0;
      end else begin
         sclk_q <= sclk;
         if (!ce) begin
            bit_q  <= '0;
            rbit_q <= '0;
            idx    <= '0;
            ph_q   <= PH_CMD;
            sdo    <= 1'b0;
            sdo_oe <= 1'b0;
         end else begin
            if (rise) begin
               sh_q  <= wr_byte;
               bit_q <= bit_q + 3'd1;
            end
            if (last_bit && ph_q == PH_CMD) begin
               cmd_q <= cmd_nxt;
               ph_q  <= cmd_nxt.valid ? PH_DATA : PH_HALT;
            end
            if (wr_stb && idx != IDX_TOP) idx <= idx + 1'b1;
            if (fall && ph_q == PH_DATA && cmd_q.rd) begin
               sdo_oe <= 1'b1;
               if (rbit_q == 3'd0) begin
                  sdo   <= rd_byte[0];
                  osh_q <= {1'b0, rd_byte[7:1]};
               end else begin
                  sdo   <= osh_q[0];
                  osh_q <= {1'b0, osh_q[7:1]};
               end
               rbit_q <= rbit_q + 3'd1;
               if (rbit_q == 3'd7 && idx != IDX_TOP) idx <= idx + 1'b1;
            end
         end
      end
   end

   // R11: line released one cycle after ce drops
   a_r11_release_on_ce_low: assert property (@(posedge clk) disable iff (!rst_n)
      !ce |=> !sdo_oe);
   // R11: only a read command drives the line
   a_r11_drive_only_read: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_oe |-> cmd_q.rd);
   // R9: abort clears the bit position
   a_r9_abort_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
      !ce |=> (bit_q == 3'd0 && rbit_q == 3'd0));
   // R10: bad command never reaches the data phase
   a_r10_bad_cmd_halts: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && last_bit && ph_q == PH_CMD && !cmd_nxt.valid) |=> (ph_q != PH_DATA));

endmodule

// File: rtl/tw_reg_slave.sv
module tw_reg_slave
   import tw_pkg::*;
#(
   parameter int TIME_REGS = 7,
   parameter int RAM_DEPTH = 31,
   parameter int DATA_W    = 8,
   parameter int WP_BIT    = 7,
   parameter bit SNAPSHOT  = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        ce,
   input  logic                        sclk,
   input  logic                        sdi,
   output logic                        sdo,
   output logic                        sdo_oe,
   input  logic [TIME_REGS*DATA_W-1:0] tm_in,
   output logic [TIME_REGS-1:0]        tm_wr_en,
   output logic [DATA_W-1:0]           tm_wr_data
);
   localparam int CLK_REGS = TIME_REGS + 1;
   localparam int IDX_W    = 6;
   localparam int RAM_AW   = 5;
   localparam logic [4:0]       CTRL_A  = 5'(TIME_REGS);
   localparam logic [IDX_W-1:0] RAM_LIM = IDX_W'(RAM_DEPTH);
   localparam logic [IDX_W-1:0] CLK_LIM = IDX_W'(CLK_REGS);

   if (DATA_W != 8) begin : g_bad_width
      $error("tw_reg_slave: DATA_W must be 8");
   end
   if (CLK_REGS > 31 || TIME_REGS < 1) begin : g_bad_time
      $error("tw_reg_slave: TIME_REGS out of range");
   end
   if (RAM_DEPTH > 31 || RAM_DEPTH < 1) begin : g_bad_ram
      $error("tw_reg_slave: RAM_DEPTH out of range");
   end
   if (WP_BIT >= DATA_W) begin : g_bad_wp
      $error("tw_reg_slave: WP_BIT outside the control byte");
   end

   tw_cmd_t           cmd_q, cmd_nxt;
   logic              cmd_stb, wr_stb;
   logic [7:0]        wr_byte, rd_byte, ram_rdata;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] ctrl_q;
   logic              wp_cmd, burst, in_range, ctrl_exempt, wr_ok;
   logic              ram_we, ctrl_we, snap_ld;
   logic [4:0]        eff_addr;
   logic [TIME_REGS-1:0]        hit;
   logic [TIME_REGS*DATA_W-1:0] burst_src;

   tw_bitlink #(.IDX_W(IDX_W)) u_link (
      .clk(clk), .rst_n(rst_n), .ce(ce), .sclk(sclk), .sdi(sdi),
      .rd_byte(rd_byte), .sdo(sdo), .sdo_oe(sdo_oe),
      .cmd_q(cmd_q), .cmd_nxt(cmd_nxt), .cmd_stb(cmd_stb),
      .wr_stb(wr_stb), .wr_byte(wr_byte), .idx(idx)
   );

   assign burst = (cmd_q.addr == TW_BURST_ADDR);

   always_comb begin
      eff_addr = burst ? idx[4:0] : cmd_q.addr;
      if (burst)
         in_range = idx < (cmd_q.ram ? RAM_LIM : CLK_LIM);
      else
         in_range = (idx == '0) &&
                    ({1'b0, cmd_q.addr} < (cmd_q.ram ? RAM_LIM : CLK_LIM));
   end

   assign ctrl_exempt = !burst && !cmd_q.ram && (cmd_q.addr == CTRL_A);
   assign wr_ok   = wr_stb && cmd_q.valid && in_range && (!wp_cmd || ctrl_exempt);
   assign ram_we  = wr_ok && cmd_q.ram;
   assign ctrl_we = wr_ok && !cmd_q.ram && (eff_addr == CTRL_A);
   assign snap_ld = cmd_stb && cmd_nxt.valid && cmd_nxt.rd && !cmd_nxt.ram &&
                    (cmd_nxt.addr == TW_BURST_ADDR);

   for (genvar g = 0; g < TIME_REGS; g++) begin : g_time_hit
      assign hit[g] = wr_ok && !cmd_q.ram && (eff_addr == 5'(g));
   end

   if (SNAPSHOT) begin : g_snap
      logic [TIME_REGS*DATA_W-1:0] shadow_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       shadow_q <= '0;
         else if (snap_ld) shadow_q <= tm_in;
      end
      assign burst_src = shadow_q;
   end else begin : g_live
      assign burst_src = tm_in;
      logic unused_snap;
      assign unused_snap = snap_ld;
   end

   tw_ram #(.DEPTH(RAM_DEPTH), .DATA_W(DATA_W), .ADDR_W(RAM_AW)) u_ram (
      .clk(clk), .rst_n(rst_n), .we(ram_we), .waddr(eff_addr),
      .wdata(wr_byte), .raddr(eff_addr), .rdata(ram_rdata)
   );

   always_comb begin
      rd_byte = '0;
      if (in_range) begin
         if (cmd_q.ram)              rd_byte = ram_rdata;
         else if (eff_addr == CTRL_A) rd_byte = ctrl_q;
         else begin
            for (int k = 0; k < TIME_REGS; k++)
               if (eff_addr == 5'(k))
                  rd_byte = burst ? burst_src[k*DATA_W +: DATA_W]
                                  : tm_in[k*DATA_W +: DATA_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tm_wr_en   <= '0;
         tm_wr_data <= '0;
         ctrl_q     <= '0;
         wp_cmd     <= 1'b0;
      end else begin
         tm_wr_en <= hit;
         if (|hit)    tm_wr_data <= wr_byte;
         if (ctrl_we) ctrl_q     <= wr_byte;
         if (cmd_stb) wp_cmd     <= ctrl_q[WP_BIT];
      end
   end

   // R4: at most one time strobe per cycle
   a_r4_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tm_wr_en));
   // R7: protected commands produce no time strobe
   a_r7_wp_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (|tm_wr_en) |-> !wp_cmd);
   // R7: protected commands leave the RAM untouched
   a_r7_wp_no_ram_write: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> !wp_cmd);
   // R7/R8: under protection only a single control write changes control
   a_r8_ctrl_change_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && wp_cmd && !ctrl_exempt) |=> $stable(ctrl_q));

endmodule

// File: tb/tb_tw_reg_slave.sv
module tb_tw_reg_slave;
   localparam int HALF = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce = 1'b0, sclk = 1'b0, sdi = 1'b0;
   logic        sdo, sdo_oe;
   logic [55:0] tm_in = '0;
   logic [6:0]  tm_wr_en;
   logic [7:0]  tm_wr_data;

   tw_reg_slave dut (
      .clk(clk), .rst_n(rst_n), .ce(ce), .sclk(sclk), .sdi(sdi),
      .sdo(sdo), .sdo_oe(sdo_oe), .tm_in(tm_in),
      .tm_wr_en(tm_wr_en), .tm_wr_data(tm_wr_data)
   );

   always #10 clk = ~clk;

   int n_vec = 0, n_bad = 0;
   bit finished = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic [7:0] obs;
   event       obs_ev;
   int         stb_cnt = 0;
   logic [6:0] stb_en;
   logic [7:0] stb_d;

   always @(negedge clk) if (|tm_wr_en) begin
      stb_cnt++;
      stb_en = tm_wr_en;
      stb_d  = tm_wr_data;
   end

   // scoreboard monitor
   always @(obs_ev) begin
      n_vec++;
      if (exp_q.size() == 0) begin
         n_bad++;
         $display("FAIL scoreboard: read %02h expected none", obs);
      end else begin
         logic [7:0] e;
         string r;
         e = exp_q.pop_front();
         r = tag_q.pop_front();
         if (obs !== e) begin
            n_bad++;
            $display("FAIL %s: read %02h expected %02h", r, obs, e);
         end
      end
   end

   task automatic chk(bit ok, string r, int act, int expv);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", r, act, expv);
      end
   endtask

   task automatic tick(int n); repeat (n) @(negedge clk); endtask
   task automatic put_bit(logic b);
      sdi = b; tick(HALF); sclk = 1'b1; tick(HALF); sclk = 1'b0; tick(HALF);
   endtask
   task automatic put_byte(logic [7:0] b);
      for (int i = 0; i < 8; i++) put_bit(b[i]);
   endtask
   task automatic get_byte();
      logic [7:0] v;
      for (int i = 0; i < 8; i++) begin
         v[i] = sdo; sclk = 1'b1; tick(HALF); sclk = 1'b0; tick(HALF);
      end
      obs = v; ->obs_ev; tick(1);
   endtask
   task automatic expect_rd(logic [7:0] e, string r);
      exp_q.push_back(e); tag_q.push_back(r);
   endtask
   task automatic go(); ce = 1'b1; tick(HALF); endtask
   task automatic stop(); ce = 1'b0; sclk = 1'b0; tick(3*HALF); endtask

   function automatic logic [7:0] cmd(bit rd, bit ram, logic [4:0] a);
      return {1'b1, ram, a, rd};
   endfunction

   task automatic wr1(bit ram, logic [4:0] a, logic [7:0] d);
      go(); put_byte(cmd(0, ram, a)); put_byte(d); stop();
   endtask
   task automatic rd1(bit ram, logic [4:0] a, logic [7:0] e, string r);
      go(); put_byte(cmd(1, ram, a)); expect_rd(e, r); get_byte(); stop();
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_vec++; n_bad++;
      $display("FAIL watchdog: run hung, got 0 expected 1");
      summary();
   end

   initial begin
      int base;
      tick(5); rst_n = 1'b1; tick(5);
      // R1 reset state
      chk(sdo_oe == 1'b0, "R1 oe", sdo_oe, 0);
      chk(tm_wr_en == '0, "R1 strobes", tm_wr_en, 0);
      rd1(0, 5'd7, 8'h00, "R1 control");

      // R2/R3 single RAM write then read, data LSB first
      wr1(1, 5'd5, 8'hA5);
      wr1(1, 5'd6, 8'h3C);
      rd1(1, 5'd5, 8'hA5, "R2 ram5");
      rd1(1, 5'd6, 8'h3C, "R3 ram6");

      // R4 single time write strobe
      base = stb_cnt;
      wr1(0, 5'd2, 8'h37);
      chk(stb_cnt == base + 1, "R4 strobe count", stb_cnt - base, 1);
      chk(stb_en == 7'b0000100 && stb_d == 8'h37, "R4 strobe", {stb_en, stb_d}, {7'b0000100, 8'h37});

      // R4 single read of live time
      tm_in = 56'h66_55_44_33_22_11_00;
      rd1(0, 5'd3, 8'h33, "R4 live read");

      // R11 drive window
      go(); put_byte(cmd(1, 0, 5'd1));
      chk(sdo_oe == 1'b1, "R11 oe after cmd", sdo_oe, 1);
      expect_rd(8'h11, "R11 data"); get_byte(); stop();
      chk(sdo_oe == 1'b0, "R11 release", sdo_oe, 0);
      go(); put_byte(cmd(0, 1, 5'd9)); put_bit(1'b1);
      chk(sdo_oe == 1'b0, "R11 write no drive", sdo_oe, 0);
      stop();

      // R5 RAM burst write and read, plus R12 byte past end
      go(); put_byte(cmd(0, 1, 5'h1F));
      for (int i = 0; i < 31; i++) put_byte(8'(i * 7 + 1));
      stop();
      go(); put_byte(cmd(1, 1, 5'h1F));
      for (int i = 0; i < 31; i++) begin expect_rd(8'(i * 7 + 1), "R5 ram burst"); get_byte(); end
      expect_rd(8'h00, "R12 past ram end"); get_byte();
      stop();

      // R5 clock burst write, wp clear
      base = stb_cnt;
      go(); put_byte(cmd(0, 0, 5'h1F));
      for (int i = 0; i < 7; i++) put_byte(8'(8'h10 + i));
      put_byte(8'h00);
      stop();
      chk(stb_cnt == base + 7, "R5 clock burst strobes", stb_cnt - base, 7);
      chk(stb_en == 7'b1000000 && stb_d == 8'h16, "R5 last strobe", {stb_en, stb_d}, {7'b1000000, 8'h16});

      // R6 clock burst read from snapshot
      tm_in = 56'h70_60_50_40_30_20_10;
      go(); put_byte(cmd(1, 0, 5'h1F));
      expect_rd(8'h10, "R6 snap0"); get_byte();
      tm_in = 56'hF7_F6_F5_F4_F3_F2_F1;
      for (int i = 1; i < 7; i++) begin expect_rd(8'(8'h10 * (i + 1)), "R6 snapshot"); get_byte(); end
      expect_rd(8'h00, "R5 control in burst"); get_byte();
      expect_rd(8'h00, "R12 past clock end"); get_byte();
      stop();
      rd1(0, 5'd1, 8'hF2, "R6 live after burst");

      // R12 unreachable clock address, extra single bytes
      wr1(0, 5'd8, 8'h5A);
      rd1(0, 5'd8, 8'h00, "R12 addr8");
      go(); put_byte(cmd(0, 1, 5'd3)); put_byte(8'h99); put_byte(8'h77); stop();
      rd1(1, 5'd4, 8'd29, "R12 extra byte dropped");
      rd1(1, 5'd3, 8'h99, "R12 single first byte");

      // R7 write protect
      wr1(0, 5'd7, 8'h80);
      base = stb_cnt;
      go(); put_byte(cmd(0, 0, 5'h1F));
      for (int i = 0; i < 8; i++) put_byte(8'h55);
      stop();
      chk(stb_cnt == base, "R7 burst strobes", stb_cnt - base, 0);
      rd1(0, 5'd7, 8'h80, "R7 control kept");
      wr1(1, 5'd5, 8'hFF);
      rd1(1, 5'd5, 8'd36, "R7 ram kept");
      wr1(0, 5'd0, 8'h01);
      chk(stb_cnt == base, "R7 single strobe", stb_cnt - base, 0);

      // R8 lifting protection
      wr1(0, 5'd7, 8'h00);
      rd1(0, 5'd7, 8'h00, "R8 control cleared");
      wr1(1, 5'd5, 8'hC3);
      rd1(1, 5'd5, 8'hC3, "R8 write after clear");

      // R9 abort mid byte
      go(); put_byte(cmd(0, 1, 5'd6));
      for (int i = 0; i < 4; i++) put_bit(1'b0);
      stop();
      rd1(1, 5'd6, 8'd43, "R9 partial discarded");

      // R10 bad command
      go(); put_byte(8'h7F & cmd(0, 1, 5'd9)); put_byte(8'hEE); stop();
      rd1(1, 5'd9, 8'd64, "R10 no write");
      go(); put_byte(8'h7F & cmd(1, 1, 5'd9)); put_bit(1'b0);
      chk(sdo_oe == 1'b0, "R10 no drive", sdo_oe, 0);
      stop();

      tick(20);
      summary();
   end
endmodule